// File: doc/BRIEF.md
# Data Miss Servicing Unit with Line Buffer

This block takes a data access that has already missed the cache and decides how it is served outside the core. Three policy bits choose the route: a cachable load or store either allocates a whole line into the cache or becomes a single-word external access. An uncachable load, or a cachable load routed around allocation, either reads just the target word or reads the whole 32-byte line into a private eight-word buffer. The line buffer is never copied into the cache. While it holds a valid line, later loads to that line are answered from it in one cycle, with no external traffic.

Several events discard the buffered line:
- a new buffered read starting;
- a store to the line;
- an invalidate aimed at the line;
- a barrier strobe.

Guarded uncachable loads always go out as single-word reads and are never answered from the buffer.

A three-state controller runs the single external transaction:
- `ST_IDLE` accepts requests and answers buffer hits.
- `ST_IDLE -> ST_ISSUE` when an accepted request misses the buffer.
- In `ST_ISSUE` the bus request is held.
- `ST_ISSUE -> ST_BEATS` on the bus ready handshake.
- In `ST_BEATS` data beats are counted.
- `ST_BEATS -> ST_IDLE` on the final beat: beat eight for line reads, beat one for word accesses.

Top module: `miss_svc`

## Requirements
- R1: A cachable load with `cfg_load_noalloc`=0 issues a line read (kind 1, address with bits [4:0] cleared). Its eight beats appear on the cache fill port with `cfill_idx` equal to the beat number. The target word, selected by address bits [4:2], is returned on `rsp_rdata` with `rsp_valid` one cycle after its beat.
- R2: A cachable load with `cfg_load_noalloc`=1 and `cfg_load_as_line`=0, or an uncachable load with `cfg_load_as_line`=0, issues a word read (kind 0, address bits [1:0] cleared). It finishes on its single beat, and that beat is returned to the requester.
- R3: A non-guarded load that bypasses allocation with `cfg_load_as_line`=1 issues a line read. Its beats go into the line buffer and never onto the cache fill port, and the target word is returned one cycle after its beat arrives.
- R4: A non-guarded load to the buffered line while the buffer is valid gets `rsp_valid` with the buffered word on the next cycle. It raises neither `ext_req_valid` nor `req_busy`.
- R5: An accepted store whose line matches the buffered line discards the buffer.
- R6: An `inv_valid` pulse whose line matches the buffered line discards the buffer. A non-matching one leaves it valid.
- R7: A `sync_strobe` pulse discards the buffer.
- R8: Starting a new buffered line read discards the previously buffered line.
- R9: A guarded uncachable load is always a word read (kind 0), even with `cfg_load_as_line`=1, and never hits the buffer.
- R10: A cachable store with `cfg_store_noalloc`=0 issues a line read onto the cache fill port and completes with `rsp_valid` after beat eight. With `cfg_store_noalloc`=1, or when uncachable, it issues a word write (kind 2) carrying `req_wdata` and completes on its single beat.
- R11: Only one external transaction runs at a time. `req_busy` is high from the cycle after a miss is accepted until its last beat. `ext_req_valid`, kind and address hold steady until `ext_req_ready`.
- R12: After reset, `req_busy`, `ext_req_valid`, `rsp_valid` and `cfill_valid` are low, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Miss request present (accepted when not busy) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Store data |
| req_cacheable | input | 1 | Region is cachable |
| req_guarded | input | 1 | Region is guarded |
| cfg_load_noalloc | input | 1 | Cachable load misses do not allocate |
| cfg_load_as_line | input | 1 | Non-allocating loads fetch a whole line into the buffer |
| cfg_store_noalloc | input | 1 | Cachable store misses do not allocate |
| inv_valid | input | 1 | Cache invalidate operation strobe |
| inv_addr | input | ADDR_W | Address targeted by the invalidate |
| sync_strobe | input | 1 | Barrier event |
| req_busy | output | 1 | External transaction in progress |
| rsp_valid | output | 1 | Completion pulse (load data valid for loads) |
| rsp_rdata | output | DATA_W | Load data |
| ext_req_valid | output | 1 | External request |
| ext_req_ready | input | 1 | External request accepted |
| ext_req_kind | output | 2 | 0 word read, 1 line read, 2 word write |
| ext_req_addr | output | ADDR_W | External address |
| ext_req_wdata | output | DATA_W | External write data |
| ext_rsp_valid | input | 1 | Response beat strobe |
| ext_rsp_data | input | DATA_W | Response beat data |
| cfill_valid | output | 1 | Beat to be written into the cache |
| cfill_idx | output | 3 | Word index of the cache fill beat |
| cfill_data | output | DATA_W | Cache fill data |

## Verification
A buffer wrongly left valid shows up on the very next load to the same line. That load returns `rsp_valid` one cycle after acceptance with no `ext_req_valid`, when a bus request was expected. A buffer wrongly dropped shows the opposite, a bus request where a one-cycle answer was due. A wrong route shows in the first cycle after acceptance, as the wrong `ext_req_kind` or address. A misplaced beat counter shows as `rsp_valid` on the wrong beat, or as `req_busy` falling early or late. The bench's behavioural model tracks the buffered line and compares these ports at every clock of each transaction.

// File: rtl/miss_svc_pkg.sv
package miss_svc_pkg;

    typedef enum logic [1:0] {
        PATH_CACHE_LINE = 2'd0,
        PATH_WORD_RD    = 2'd1,
        PATH_BUF_LINE   = 2'd2,
        PATH_WORD_WR    = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_BEATS = 2'd2
    } fsm_e;

    localparam logic [1:0] KIND_RD_WORD = 2'd0;
    localparam logic [1:0] KIND_RD_LINE = 2'd1;
    localparam logic [1:0] KIND_WR_WORD = 2'd2;

endpackage

// File: rtl/miss_decode.sv
module miss_decode
    import miss_svc_pkg::*;
(
    input  logic  is_write,
    input  logic  cacheable,
    input  logic  guarded,
    input  logic  load_noalloc,
    input  logic  load_as_line,
    input  logic  store_noalloc,
    output path_e path
);

    always_comb begin
        if (is_write) begin
            path = (cacheable && !store_noalloc) ? PATH_CACHE_LINE : PATH_WORD_WR;
        end else if (cacheable && !load_noalloc) begin
            path = PATH_CACHE_LINE;
        end else if (load_as_line && !guarded) begin
            path = PATH_BUF_LINE;
        end else begin
            path = PATH_WORD_RD;
        end
    end

endmodule

// File: rtl/line_buf.sv
module line_buf #(
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int TAG_W      = 27,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fill_start,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_done,
    input  logic              sync_kill,
    input  logic              inv_valid,
    input  logic [TAG_W-1:0]  inv_tag,
    input  logic              st_valid,
    input  logic [TAG_W-1:0]  st_tag
);

    logic                           valid_q;
    logic                           filling_q;
    logic                           doomed_q;
    logic [TAG_W-1:0]               tag_q;
    logic [LINE_WORDS-1:0][DATA_W-1:0] words_q;
    logic                           kill_now;

    assign kill_now = sync_kill
                    || (inv_valid && inv_tag == tag_q)
                    || (st_valid && st_tag == tag_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            filling_q <= 1'b0;
            doomed_q  <= 1'b0;
            tag_q     <= '0;
        end else if (fill_start) begin
            valid_q   <= 1'b0;
            filling_q <= 1'b1;
            doomed_q  <= 1'b0;
            tag_q     <= fill_tag;
        end else begin
            if (kill_now) begin
                valid_q <= 1'b0;
            end
            if (filling_q && kill_now) begin
                doomed_q <= 1'b1;
            end
            if (fill_done) begin
                filling_q <= 1'b0;
                valid_q   <= !(doomed_q || kill_now);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    assign hit     = valid_q && (look_tag == tag_q) && !kill_now;
    assign rd_data = words_q[look_idx];

    a_r7_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_kill |=> !valid_q);

    a_r5_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_tag == tag_q) |=> !valid_q);

    a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_tag == tag_q) |=> !valid_q);

    a_r3_valid_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(fill_done));

endmodule

// File: rtl/miss_svc.sv
module miss_svc
    import miss_svc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int BYTE_OFS  = $clog2(DATA_W / 8),
    localparam int LINE_OFS  = BYTE_OFS + IDX_W,
    localparam int TAG_W     = ADDR_W - LINE_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_cacheable,
    input  logic              req_guarded,
    input  logic              cfg_load_noalloc,
    input  logic              cfg_load_as_line,
    input  logic              cfg_store_noalloc,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              sync_strobe,
    output logic              req_busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ext_req_valid,
    input  logic              ext_req_ready,
    output logic [1:0]        ext_req_kind,
    output logic [ADDR_W-1:0] ext_req_addr,
    output logic [DATA_W-1:0] ext_req_wdata,
    input  logic              ext_rsp_valid,
    input  logic [DATA_W-1:0] ext_rsp_data,
    output logic              cfill_valid,
    output logic [IDX_W-1:0]  cfill_idx,
    output logic [DATA_W-1:0] cfill_data
);

    fsm_e              state_q;
    path_e             dec_path;
    path_e             path_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  beat_q;
    logic              write_q;

    logic              accept;
    logic              buf_hit;
    logic              hit_use;
    logic              start_ext;
    logic              fill_start;
    logic              beat_ok;
    logic              is_line_q;
    logic              last_beat;
    logic [DATA_W-1:0] buf_word;

    miss_decode u_decode (
        .is_write      (req_write),
        .cacheable     (req_cacheable),
        .guarded       (req_guarded),
        .load_noalloc  (cfg_load_noalloc),
        .load_as_line  (cfg_load_as_line),
        .store_noalloc (cfg_store_noalloc),
        .path          (dec_path)
    );

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign hit_use    = accept && !req_write && !req_guarded && buf_hit;
    assign start_ext  = accept && !hit_use;
    assign fill_start = start_ext && (dec_path == PATH_BUF_LINE);
    assign is_line_q  = (path_q == PATH_CACHE_LINE) || (path_q == PATH_BUF_LINE);
    assign beat_ok    = (state_q == ST_BEATS) && ext_rsp_valid;
    assign last_beat  = beat_ok && (!is_line_q || beat_q == IDX_W'(LINE_WORDS - 1));

    line_buf #(
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .TAG_W      (TAG_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_tag   (req_addr[ADDR_W-1:LINE_OFS]),
        .look_idx   (req_addr[LINE_OFS-1:BYTE_OFS]),
        .hit        (buf_hit),
        .rd_data    (buf_word),
        .fill_start (fill_start),
        .fill_tag   (req_addr[ADDR_W-1:LINE_OFS]),
        .wr_en      (beat_ok && path_q == PATH_BUF_LINE),
        .wr_idx     (beat_q),
        .wr_data    (ext_rsp_data),
        .fill_done  (last_beat && path_q == PATH_BUF_LINE),
        .sync_kill  (sync_strobe),
        .inv_valid  (inv_valid),
        .inv_tag    (inv_addr[ADDR_W-1:LINE_OFS]),
        .st_valid   (accept && req_write),
        .st_tag     (req_addr[ADDR_W-1:LINE_OFS])
    );

    // State register and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            path_q  <= PATH_WORD_RD;
            addr_q  <= '0;
            wdata_q <= '0;
            beat_q  <= '0;
            write_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ext) begin
                        state_q <= ST_ISSUE;
                        path_q  <= dec_path;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        write_q <= req_write;
                        beat_q  <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (ext_req_ready) begin
                        state_q <= ST_BEATS;
                    end
                end
                ST_BEATS: begin
                    if (beat_ok) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (hit_use) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= buf_word;
            end else if (beat_ok) begin
                if (!write_q && (!is_line_q || beat_q == addr_q[LINE_OFS-1:BYTE_OFS])) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= ext_rsp_data;
                end else if (write_q && last_beat) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= '0;
                end
            end
        end
    end

    assign req_busy      = (state_q != ST_IDLE);
    assign ext_req_valid = (state_q == ST_ISSUE);
    assign ext_req_kind  = is_line_q ? KIND_RD_LINE
                         : (path_q == PATH_WORD_WR) ? KIND_WR_WORD : KIND_RD_WORD;
    assign ext_req_addr  = is_line_q ? {addr_q[ADDR_W-1:LINE_OFS], {LINE_OFS{1'b0}}}
                                     : {addr_q[ADDR_W-1:BYTE_OFS], {BYTE_OFS{1'b0}}};
    assign ext_req_wdata = wdata_q;
    assign cfill_valid   = beat_ok && (path_q == PATH_CACHE_LINE);
    assign cfill_idx     = beat_q;
    assign cfill_data    = ext_rsp_data;

    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_valid && !ext_req_ready) |=>
            (ext_req_valid && $stable(ext_req_addr) && $stable(ext_req_kind)));

    a_r11_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_valid |-> req_busy);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> (!ext_req_valid && !cfill_valid));

    a_r2_word_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && ext_req_kind != KIND_RD_LINE) |=> !req_busy);

    a_r4_hit_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        hit_use |=> (!ext_req_valid && rsp_valid));

endmodule

// File: tb/test_miss_svc.sv
module test_miss_svc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_cacheable = 1'b0, req_guarded = 1'b0;
    logic        cfg_load_noalloc = 1'b0, cfg_load_as_line = 1'b0, cfg_store_noalloc = 1'b0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_addr = '0;
    logic        sync_strobe = 1'b0;
    logic        req_busy, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ext_req_valid;
    logic        ext_req_ready = 1'b0;
    logic [1:0]  ext_req_kind;
    logic [31:0] ext_req_addr, ext_req_wdata;
    logic        ext_rsp_valid = 1'b0;
    logic [31:0] ext_rsp_data = '0;
    logic        cfill_valid;
    logic [2:0]  cfill_idx;
    logic [31:0] cfill_data;

    int n_checks = 0;
    int n_errors = 0;

    // Behavioural model of the buffered line
    bit          m_valid = 1'b0;
    logic [26:0] m_tag = '0;

    miss_svc i_miss_svc (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] memword(logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0003;
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic access(bit wr, logic [31:0] a, bit c, bit g, bit lwoa, bit lwl,
                          bit swoa, string r);
        bit          hit_e, line_e, to_cache, to_buf, exp_rsp;
        logic [1:0]  kind_e;
        logic [31:0] ba;
        int          nb;
        hit_e    = !wr && !g && m_valid && (a[31:5] == m_tag);
        to_cache = 1'b0;
        to_buf   = 1'b0;
        if (wr) begin
            to_cache = c && !swoa;
            kind_e   = to_cache ? 2'd1 : 2'd2;
        end else if (c && !lwoa) begin
            to_cache = 1'b1;
            kind_e   = 2'd1;
        end else if (lwl && !g) begin
            to_buf = 1'b1;
            kind_e = 2'd1;
        end else begin
            kind_e = 2'd0;
        end
        line_e = to_cache || to_buf;

        @(negedge clk);
        chk({r, " R11 idle before request"}, req_busy, 0);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = ~a;
        req_cacheable = c; req_guarded = g;
        cfg_load_noalloc = lwoa; cfg_load_as_line = lwl; cfg_store_noalloc = swoa;
        @(negedge clk);
        req_valid = 1'b0;

        if (hit_e) begin
            chk({r, " R4 hit rsp_valid"}, rsp_valid, 1);
            chk({r, " R4 hit data"}, rsp_rdata, memword(a));
            chk({r, " R4 hit no ext"}, ext_req_valid, 0);
            chk({r, " R4 hit not busy"}, req_busy, 0);
            return;
        end

        if (wr && a[31:5] == m_tag) m_valid = 1'b0;
        if (to_buf) m_valid = 1'b0;

        chk({r, " R11 ext request"}, ext_req_valid, 1);
        chk({r, " R11 busy"}, req_busy, 1);
        chk({r, " kind"}, ext_req_kind, kind_e);
        chk({r, " address"}, ext_req_addr, line_e ? {a[31:5], 5'b0} : {a[31:2], 2'b0});
        if (kind_e == 2'd2) chk({r, " R10 write data"}, ext_req_wdata, ~a);
        @(negedge clk);
        chk({r, " R11 request held"}, ext_req_valid, 1);
        chk({r, " R11 kind held"}, ext_req_kind, kind_e);
        ext_req_ready = 1'b1;
        @(negedge clk);
        ext_req_ready = 1'b0;
        chk({r, " R11 request dropped"}, ext_req_valid, 0);
        chk({r, " R11 busy in beats"}, req_busy, 1);

        nb = line_e ? 8 : 1;
        for (int i = 0; i < nb; i++) begin
            ba = line_e ? ({a[31:5], 5'b0} + 32'(i * 4)) : a;
            ext_rsp_valid = 1'b1;
            ext_rsp_data  = memword(ba);
            #1;
            chk({r, " R1 R3 cache fill strobe"}, cfill_valid, to_cache);
            if (to_cache) chk({r, " R1 fill index"}, cfill_idx, i);
            @(negedge clk);
            ext_rsp_valid = 1'b0;
            exp_rsp = wr ? (i == nb - 1) : (line_e ? (i == int'(a[4:2])) : 1'b1);
            chk({r, " R1 R2 R3 R10 rsp timing"}, rsp_valid, exp_rsp);
            if (exp_rsp && !wr) chk({r, " R1 R2 R3 rsp data"}, rsp_rdata, memword(a));
            chk({r, " R11 busy until last beat"}, req_busy, (i == nb - 1) ? 0 : 1);
        end
        if (to_buf) begin
            m_valid = 1'b1;
            m_tag   = a[31:5];
        end
    endtask

    task automatic pulse_inv(logic [31:0] a);
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
        if (a[31:5] == m_tag) m_valid = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync_strobe = 1'b1;
        @(negedge clk);
        sync_strobe = 1'b0;
        m_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset busy", req_busy, 0);
        chk("R12 reset ext_req_valid", ext_req_valid, 0);
        chk("R12 reset rsp_valid", rsp_valid, 0);
        chk("R12 reset cfill_valid", cfill_valid, 0);

        // wr, addr, cach, guard, lwoa, lwl, swoa
        access(0, 32'h2000_0008, 0, 0, 0, 1, 0, "R12 first buffered load misses");
        access(0, 32'h1000_0014, 1, 0, 0, 0, 0, "R1 cachable allocating load");
        access(0, 32'h1000_0024, 1, 0, 1, 0, 0, "R2 cachable word load");
        access(0, 32'h3000_0104, 0, 0, 0, 0, 0, "R2 uncachable word load");
        access(0, 32'h2000_001C, 0, 0, 0, 1, 0, "R4 buffer hit last word");
        access(0, 32'h2000_0000, 0, 0, 0, 1, 0, "R4 buffer hit first word");

        pulse_inv(32'h3000_0000);
        access(0, 32'h2000_0010, 0, 0, 0, 1, 0, "R6 unrelated invalidate keeps line");
        pulse_inv(32'h2000_0004);
        access(0, 32'h2000_0010, 0, 0, 0, 1, 0, "R6 matching invalidate refetch");
        access(0, 32'h2000_0014, 0, 0, 0, 1, 0, "R6 refilled line hit");

        pulse_sync();
        access(0, 32'h2000_0018, 0, 0, 0, 1, 0, "R7 sync forces refetch");

        access(1, 32'h2000_0004, 0, 0, 0, 1, 0, "R10 uncachable word write");
        access(0, 32'h2000_000C, 0, 0, 0, 1, 0, "R5 store dropped line");

        access(0, 32'h4000_0044, 0, 0, 0, 1, 0, "R8 new line fetch");
        access(0, 32'h4000_0048, 0, 0, 0, 1, 0, "R8 new line hit");
        access(0, 32'h2000_0008, 0, 0, 0, 1, 0, "R8 old line gone");
        access(0, 32'h4000_0040, 0, 0, 0, 1, 0, "R8 replaced line gone");

        access(0, 32'h2000_0008, 0, 1, 0, 1, 0, "R9 guarded word read");
        access(0, 32'h2000_0008, 0, 1, 0, 1, 0, "R9 guarded re-requested");

        access(1, 32'h5000_0030, 1, 0, 0, 0, 0, "R10 cachable store line fill");
        access(1, 32'h5000_0030, 1, 0, 0, 0, 1, "R10 cachable store no allocate");

        access(0, 32'h6000_0038, 1, 0, 1, 1, 0, "R3 cachable non-allocating line");
        access(0, 32'h6000_0020, 1, 0, 1, 1, 0, "R4 hit after cachable line");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule